// File: doc/BRIEF.md
# Tracking Up/Down Counter Converter Controller

This block is the digital half of a servo-style analog-to-digital converter. It owns the code that feeds an external DAC. On every clock it moves that code one LSB toward the analog input, using a two-flag window comparator: one flag says the input is above the DAC level and the other says it is below. With both flags low the code holds. In this way the code follows a slowly changing input.

A freeze input stops tracking at any chosen cycle and keeps the code for as long as it stays asserted, so the block can act as a digital sample-and-hold. Two inhibit inputs block upward or downward steps on their own. With upward steps blocked, the code falls to and stays at the lowest level the input reached. With downward steps blocked, it keeps the highest level.

A second mode runs a single-shot counting conversion. A start pulse clears the code to zero. The code then climbs one LSB per clock until the input is no longer above the DAC. Then a done flag rises, and the result holds until the next start.

Top module: `servo_track_conv`

## Requirements
- R1: In tracking mode (`shot_mode`=0, `freeze`=0, no inhibit), the code rises by 1 at the next edge when `cmp_above`=1 and `cmp_below`=0, falls by 1 when `cmp_below`=1 and `cmp_above`=0, and otherwise holds. With an input level v in LSB units, it therefore settles at exactly v.
- R2: The code saturates at 0 and at 2^WIDTH-1 and never wraps, in any mode.
- R3: While `freeze`=1, the code, `busy` and `done` all keep their values and `start` is ignored. Operation resumes from the held state when `freeze` returns to 0.
- R4: In tracking mode with `inhibit_up`=1, the code never rises. It settles at the minimum input level seen since the inhibit was applied, provided that level is below the starting code.
- R5: In tracking mode with `inhibit_down`=1, the code never falls. It settles at the maximum input level seen, provided that level is above the starting code.
- R6: In single-shot mode (`shot_mode`=1), a clock edge with `start`=1 sets the code to 0, `busy` to 1 and `done` to 0.
- R7: While `busy`=1, the code rises by 1 per edge as long as `cmp_above`=1 and the code is below 2^WIDTH-1. At the first edge where that fails, `busy` falls and `done` rises. An input level v therefore gives the result min(v, 2^WIDTH-1), with `done` seen min(v, 2^WIDTH-1)+1 edges after the start edge. `busy` and `done` are never both 1.
- R8: After `done` rises in single-shot mode, the code and `done` stay unchanged whatever the comparator does, until the next start.
- R9: In tracking mode, `busy` and `done` are 0 at the edge after the mode is selected, and `start` has no effect. After reset the code, `busy` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shot_mode | input | 1 | 0 = continuous tracking, 1 = single-shot counting conversion |
| start | input | 1 | Begins a single-shot conversion (single-shot mode only) |
| freeze | input | 1 | Holds the code and flags |
| inhibit_up | input | 1 | Blocks upward steps in tracking mode |
| inhibit_down | input | 1 | Blocks downward steps in tracking mode |
| cmp_above | input | 1 | Comparator: input is above the DAC level |
| cmp_below | input | 1 | Comparator: input is below the DAC level |
| dac_code | output | WIDTH | Code that drives the DAC; also the conversion result |
| busy | output | 1 | Single-shot conversion in progress |
| done | output | 1 | Single-shot result valid |

## Verification
The bench builds the block with WIDTH=4, so only 16 codes exist. This lets it sweep every target level in tracking mode. It also runs a single-shot conversion for every input level from 0 up to one beyond full scale, checking each result and its exact conversion time. With so few codes, both saturation ends and the full-scale conversion time of 2^WIDTH edges can be reached within a few cycles. The analog input is an integer level that a bench comparator model turns into the two flags, and that level may also lie below zero.

// File: rtl/trk_pkg.sv
package trk_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_CLR  = 2'd3
  } step_e;

  // Saturating next-code arithmetic on a 32-bit container.
  function automatic logic [31:0] step_apply(input logic [31:0] cur,
                                             input step_e       st,
                                             input logic [31:0] top);
    logic [31:0] nxt;
    nxt = cur;
    case (st)
      STEP_UP:   if (cur < top)   nxt = cur + 32'd1;
      STEP_DOWN: if (cur != 32'd0) nxt = cur - 32'd1;
      STEP_CLR:  nxt = 32'd0;
      default:   nxt = cur;
    endcase
    return nxt;
  endfunction

  // Direction choice of the tracking loop from the window comparator.
  function automatic step_e track_choice(input logic above, input logic below,
                                         input logic blk_up, input logic blk_dn,
                                         input logic full, input logic empty);
    step_e s;
    s = STEP_HOLD;
    if (above && !below && !blk_up && !full)      s = STEP_UP;
    else if (below && !above && !blk_dn && !empty) s = STEP_DOWN;
    return s;
  endfunction

endpackage

// File: rtl/trk_dir_sel.sv
module trk_dir_sel
  import trk_pkg::*;
(
  input  logic  cmp_above,
  input  logic  cmp_below,
  input  logic  inhibit_up,
  input  logic  inhibit_down,
  input  logic  at_max,
  input  logic  at_zero,
  output step_e track_step
);

  always_comb begin
    track_step = track_choice(cmp_above, cmp_below, inhibit_up, inhibit_down,
                              at_max, at_zero);
  end

endmodule

// File: rtl/trk_shot_seq.sv
module trk_shot_seq
  import trk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  logic  start,
  input  logic  freeze,
  input  logic  cmp_above,
  input  logic  at_max,
  output step_e shot_step,
  output logic  busy,
  output logic  done
);

  logic run_q, done_q;
  logic launch, keep_going, finish;

  assign launch     = enable && !freeze && start;
  assign keep_going = enable && !freeze && !start && run_q && cmp_above && !at_max;
  assign finish     = enable && !freeze && !start && run_q && !(cmp_above && !at_max);

  always_comb begin
    shot_step = STEP_HOLD;
    if (launch)          shot_step = STEP_CLR;
    else if (keep_going) shot_step = STEP_UP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (!enable) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (launch) begin
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (finish) begin
      run_q  <= 1'b0;
      done_q <= 1'b1;
    end
  end

  assign busy = run_q;
  assign done = done_q;

endmodule

// File: rtl/trk_code_reg.sv
module trk_code_reg
  import trk_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            step,
  output logic [WIDTH-1:0] code,
  output logic             at_max,
  output logic             at_zero
);

  localparam logic [31:0]      TOP32    = 32'((64'd1 << WIDTH) - 64'd1);
  localparam logic [WIDTH-1:0] CODE_TOP = {WIDTH{1'b1}};

  logic [WIDTH-1:0] code_q;
  logic [31:0]      next32;

  always_comb begin
    next32 = step_apply(32'(code_q), step, TOP32);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= WIDTH'(next32);
  end

  assign code    = code_q;
  assign at_max  = (code_q == CODE_TOP);
  assign at_zero = (code_q == '0);

endmodule

// File: rtl/servo_track_conv.sv
module servo_track_conv
  import trk_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shot_mode,
  input  logic             start,
  input  logic             freeze,
  input  logic             inhibit_up,
  input  logic             inhibit_down,
  input  logic             cmp_above,
  input  logic             cmp_below,
  output logic [WIDTH-1:0] dac_code,
  output logic             busy,
  output logic             done
);

  step_e track_step, shot_step, step_sel;
  logic  at_max, at_zero;

  trk_dir_sel u_dir (
    .cmp_above   (cmp_above),
    .cmp_below   (cmp_below),
    .inhibit_up  (inhibit_up),
    .inhibit_down(inhibit_down),
    .at_max      (at_max),
    .at_zero     (at_zero),
    .track_step  (track_step)
  );

  trk_shot_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (shot_mode),
    .start    (start),
    .freeze   (freeze),
    .cmp_above(cmp_above),
    .at_max   (at_max),
    .shot_step(shot_step),
    .busy     (busy),
    .done     (done)
  );

  always_comb begin
    if (freeze)         step_sel = STEP_HOLD;
    else if (shot_mode) step_sel = shot_step;
    else                step_sel = track_step;
  end

  trk_code_reg #(.WIDTH(WIDTH)) u_code (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step_sel),
    .code   (dac_code),
    .at_max (at_max),
    .at_zero(at_zero)
  );

endmodule

// File: rtl/servo_track_conv_chk.sv
module servo_track_conv_chk
  import trk_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shot_mode,
  input logic             start,
  input logic             freeze,
  input logic             inhibit_up,
  input logic             inhibit_down,
  input logic [WIDTH-1:0] dac_code,
  input logic             busy,
  input logic             done,
  input step_e            step_sel
);

  localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};

  // R1
  one_lsb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_sel != STEP_CLR) |=> ((dac_code == $past(dac_code)) ||
                                (dac_code == $past(dac_code) + 1'b1) ||
                                (dac_code == $past(dac_code) - 1'b1)));

  // R2
  no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code == FULL && step_sel != STEP_CLR) |=> (dac_code != '0));

  // R2
  no_wrap_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code == '0) |=> (dac_code != FULL));

  // R3
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && shot_mode) |=> ($stable(dac_code) && $stable(busy) && $stable(done)));

  // R4
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_up && !shot_mode) |=> (dac_code <= $past(dac_code)));

  // R5
  no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_down && !shot_mode) |=> (dac_code >= $past(dac_code)));

  // R6
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shot_mode && start && !freeze) |=> (dac_code == '0 && busy && !done));

  // R7
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shot_mode && done && !start) |=> (done && $stable(dac_code)));

  // R9
  track_flags_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shot_mode |=> (!busy && !done));

endmodule

bind servo_track_conv servo_track_conv_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .shot_mode   (shot_mode),
  .start       (start),
  .freeze      (freeze),
  .inhibit_up  (inhibit_up),
  .inhibit_down(inhibit_down),
  .dac_code    (dac_code),
  .busy        (busy),
  .done        (done),
  .step_sel    (step_sel)
);

// File: tb/servo_track_conv_bench.sv
module servo_track_conv_bench;

  localparam int W      = 4;
  localparam int TOP    = (1 << W) - 1;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shot_mode = 1'b0, start = 1'b0, freeze = 1'b0;
  logic inhibit_up = 1'b0, inhibit_down = 1'b0;
  logic cmp_above, cmp_below;
  logic [W-1:0] dac_code;
  logic busy, done;
  int   vin = 0;
  int   n_chk = 0, n_err = 0;

  always #(PERIOD/2) clk = ~clk;

  // Comparator model: input level vin in LSB units against the DAC code.
  assign cmp_above = (vin > int'(dac_code));
  assign cmp_below = (vin < int'(dac_code));

  servo_track_conv #(.WIDTH(W)) u_servo_track_conv (
    .clk(clk), .rst_n(rst_n), .shot_mode(shot_mode), .start(start),
    .freeze(freeze), .inhibit_up(inhibit_up), .inhibit_down(inhibit_down),
    .cmp_above(cmp_above), .cmp_below(cmp_below),
    .dac_code(dac_code), .busy(busy), .done(done)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    tick(1);
    start = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R9 reset state
    chk("R9 reset code", int'(dac_code), 0);
    chk("R9 reset busy", int'(busy), 0);
    chk("R9 reset done", int'(done), 0);

    // R1 trajectory
    vin = 5;
    tick(3);
    chk("R1 ramp after 3", int'(dac_code), 3);
    tick(6);
    chk("R1 settle", int'(dac_code), 5);
    vin = 2;
    tick(1);
    chk("R1 step down", int'(dac_code), 4);

    // R1 sweep of every level
    for (int t = 0; t <= TOP; t++) begin
      vin = t;
      tick(TOP + 1);
      chk("R1 sweep", int'(dac_code), t);
    end

    // R2 saturation
    vin = TOP + 1;
    tick(TOP + 4);
    chk("R2 top saturate", int'(dac_code), TOP);
    vin = -1;
    tick(TOP + 4);
    chk("R2 bottom saturate", int'(dac_code), 0);

    // R9 start ignored in tracking mode
    vin = 6;
    tick(TOP + 1);
    pulse_start();
    chk("R9 start ignored code", int'(dac_code), 6);
    chk("R9 busy low", int'(busy), 0);
    chk("R9 done low", int'(done), 0);

    // R3 freeze in tracking
    vin = 7;
    tick(TOP + 1);
    freeze = 1'b1;
    vin = 12;
    tick(10);
    chk("R3 frozen code", int'(dac_code), 7);
    freeze = 1'b0;
    tick(1);
    chk("R3 resume", int'(dac_code), 8);

    // R4 minimum capture
    vin = 9;
    tick(TOP + 1);
    inhibit_up = 1'b1;
    vin = 12; tick(10);
    chk("R4 no rise", int'(dac_code), 9);
    vin = 4;  tick(10);
    vin = 11; tick(10);
    vin = 6;  tick(10);
    chk("R4 minimum held", int'(dac_code), 4);
    inhibit_up = 1'b0;

    // R5 maximum capture
    vin = 5;
    tick(TOP + 1);
    inhibit_down = 1'b1;
    vin = 2;  tick(10);
    chk("R5 no fall", int'(dac_code), 5);
    vin = 13; tick(12);
    vin = 3;  tick(10);
    vin = 10; tick(10);
    chk("R5 maximum held", int'(dac_code), 13);
    inhibit_down = 1'b0;

    // R6/R7 single-shot sweep including above full scale
    shot_mode = 1'b1;
    tick(1);
    for (int v = 0; v <= TOP + 1; v++) begin
      int lim;
      int cnt;
      lim = (v > TOP) ? TOP : v;
      vin = v;
      pulse_start();
      chk("R6 cleared code", int'(dac_code), 0);
      chk("R6 busy set", int'(busy), 1);
      chk("R6 done cleared", int'(done), 0);
      cnt = 0;
      while (!done && cnt < 3 * (TOP + 1)) begin
        tick(1);
        cnt++;
      end
      chk("R7 conversion edges", cnt, lim + 1);
      chk("R7 result", int'(dac_code), lim);
      chk("R7 busy low at done", int'(busy), 0);
    end

    // R8 result held against comparator changes
    vin = 3;
    tick(10);
    chk("R8 result held", int'(dac_code), TOP);
    chk("R8 done held", int'(done), 1);

    // R3 freeze during a conversion
    vin = 10;
    pulse_start();
    tick(3);
    chk("R3 mid conversion", int'(dac_code), 3);
    freeze = 1'b1;
    tick(5);
    chk("R3 frozen busy code", int'(dac_code), 3);
    chk("R3 frozen busy flag", int'(busy), 1);
    freeze = 1'b0;
    tick(20);
    chk("R3 resumed result", int'(dac_code), 10);
    chk("R3 resumed done", int'(done), 1);
    freeze = 1'b1;
    pulse_start();
    tick(2);
    chk("R3 start ignored frozen", int'(dac_code), 10);
    chk("R3 done kept frozen", int'(done), 1);
    freeze = 1'b0;

    // R9 leaving single-shot mode clears the flags
    shot_mode = 1'b0;
    tick(1);
    chk("R9 done cleared", int'(done), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule